// File: doc/BRIEF.md
# Step Attenuator Control Interface

This block holds the six-bit control word of a digital step attenuator and drives it onto the attenuator's control lines. Each bit of the word carries twice the weight of the bit below it. Bit 0 is worth 0.5 dB, so the word spans 0 dB to 31.5 dB in half-decibel steps.

A mode pin selects one of two programming styles. In parallel programming, six level pins carry the word. The word is taken from those pins while the latch enable is high. Holding the enable high makes the register follow the pins. A short high pulse on the enable captures the pins at that moment. In serial programming, bits enter a six-bit shift register on each rising edge of a serial clock, most significant bit first. Raising the latch enable copies the shift register into the output word.

All external pins pass through a two-flop synchroniser on the system clock. Every edge is detected in that clock domain. A synchronous, active-high reset stands in for power-up. During reset, the starting word is chosen according to the mode pin:
- In parallel mode it comes from a two-bit preset selector.
- In serial mode it is copied from the parallel pins.

Top module: `step_atten_ctrl`

## Requirements
- R1: While reset is held in parallel mode (`serial_mode_i`=0), the word loads a preset chosen by `preset_sel_i` ({hi,lo}). 00 gives 6'b000000. Low bit only (01) gives 6'b010000 (8 dB). High bit only (10) gives 6'b100000 (16 dB). 11 gives 6'b111110 (31 dB).
- R2: While reset is held in serial mode (`serial_mode_i`=1), both the word and the shift register load the value on `par_word_i`.
- R3: In parallel mode with `latch_en_i` held high, the output follows `par_word_i`. A change appears within three system clocks.
- R4: In parallel mode with `latch_en_i` low, changes on `par_word_i` leave the output unchanged.
- R5: In parallel mode, a high pulse on `latch_en_i` loads the value present on `par_word_i` during the pulse. Later changes on the pins have no effect.
- R6: In serial mode, each rising edge of `ser_clk_i` shifts `ser_data_i` into bit 0 and moves the older bits up. After six edges, with the 16 dB bit sent first, a high level on `latch_en_i` copies the register into the output.
- R7: In serial mode with `latch_en_i` low, the output does not change while bits are shifted.
- R8: When more than six bits are shifted before the latch, only the last six bits shifted are kept.
- R9: A change of `serial_mode_i` while `latch_en_i` is low leaves the output unchanged.
- R10: Bit i of `atten_word_o` weighs 0.5·2^i dB. Bit 0 is 0.5 dB and bit 5 is 16 dB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset, models power-up |
| serial_mode_i | input | 1 | 0 selects parallel programming, 1 selects serial |
| par_word_i | input | 6 | Parallel control word; also the serial-mode power-up word |
| preset_sel_i | input | 2 | Preset selector for parallel-mode power-up |
| ser_data_i | input | 1 | Serial data bit |
| ser_clk_i | input | 1 | Serial shift clock, sampled on `clk` |
| latch_en_i | input | 1 | Latch enable for both modes |
| atten_word_o | output | 6 | Registered attenuator control word |

## Verification
The assertions check four things on every clock:
- A low synchronised enable freezes the word.
- A high enable loads the parallel pins in parallel mode, or the shift register in serial mode.
- The shift register is frozen outside serial mode.
- The first word after a parallel-mode reset is one of the four presets.

Some behaviours depend on a stimulus history, and only the bench scenarios show them:
- which preset each selector code picks;
- the serial-mode reset word;
- the most-significant-first order;
- the drop of excess bits;
- mode changes with the latch closed.

The bench checks these through a per-clock reference model and through checks at named points.

// File: rtl/step_atten_pkg.sv
package step_atten_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int unsigned WORD_W   = 6;
    localparam int unsigned PRESET_W = 2;
    localparam int unsigned SYNC_N   = 2;

    typedef logic [WORD_W-1:0] atten_word_t;

    typedef enum logic {
        CTRL_PARALLEL = 1'b0,
        CTRL_SERIAL   = 1'b1
    } ctrl_mode_e;

    // Bundle of every external pin, carried through one synchroniser.
    typedef struct packed {
        ctrl_mode_e            mode;
        atten_word_t           par;
        logic [PRESET_W-1:0]   preset;
        logic                  sdata;
        logic                  sclk;
        logic                  le;
    } pin_bundle_t;

    localparam int unsigned PIN_W = $bits(pin_bundle_t);

    // Power-up word for parallel mode: low selector bit adds the 8 dB step,
    // high bit the 16 dB step, both together give every step except 0.5 dB.
    function automatic atten_word_t preset_word(input logic [PRESET_W-1:0] sel);
        atten_word_t w;
        case (sel)
            2'b01:   w = atten_word_t'(1) << (WORD_W - 2);
            2'b10:   w = atten_word_t'(1) << (WORD_W - 1);
            2'b11:   w = {{(WORD_W-1){1'b1}}, 1'b0};
            default: w = '0;
        endcase
        return w;
    endfunction
endpackage

// File: rtl/atten_pin_sync.sv
module atten_pin_sync #(
    parameter int unsigned WIDTH  = 1,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    timeunit 1ns;
    timeprecision 1ps;

    generate
        if (STAGES <= 1) begin : g_single
            logic [WIDTH-1:0] stage_q;
            always_ff @(posedge clk) stage_q <= d;
            assign q = stage_q;
        end else begin : g_chain
            logic [STAGES-1:0][WIDTH-1:0] chain_q;
            always_ff @(posedge clk) chain_q <= {chain_q[STAGES-2:0], d};
            assign q = chain_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/atten_shift_reg.sv
module atten_shift_reg
    import step_atten_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        enable,
    input  logic        sclk_s,
    input  logic        sdata_s,
    input  atten_word_t init_word,
    output atten_word_t shift_word
);
    timeunit 1ns;
    timeprecision 1ps;

    logic        sclk_prev_q;
    logic        shift_now;
    atten_word_t shreg_q;

    assign shift_now = enable & sclk_s & ~sclk_prev_q;

    always_ff @(posedge clk) begin
        sclk_prev_q <= sclk_s;
        if (rst) begin
            shreg_q <= init_word;
        end else if (shift_now) begin
            shreg_q <= {shreg_q[WORD_W-2:0], sdata_s};
        end
    end

    assign shift_word = shreg_q;

    // R7: outside serial mode nothing disturbs the staged word
    assert_shift_idle_R7: assert property (@(posedge clk) disable iff (rst)
        !enable |=> $stable(shreg_q));
endmodule

// File: rtl/atten_word_reg.sv
module atten_word_reg
    import step_atten_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        load,
    input  atten_word_t init_word,
    input  atten_word_t load_word,
    output atten_word_t word_o
);
    timeunit 1ns;
    timeprecision 1ps;

    atten_word_t word_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= init_word;
        end else if (load) begin
            word_q <= load_word;
        end
    end

    assign word_o = word_q;
endmodule

// File: rtl/step_atten_ctrl.sv
module step_atten_ctrl
    import step_atten_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       serial_mode_i,
    input  logic [5:0] par_word_i,
    input  logic [1:0] preset_sel_i,
    input  logic       ser_data_i,
    input  logic       ser_clk_i,
    input  logic       latch_en_i,
    output logic [5:0] atten_word_o
);
    timeunit 1ns;
    timeprecision 1ps;

    pin_bundle_t pins_raw, pins_s;
    atten_word_t shift_word, init_word, load_word, word_q;
    logic        serial_s;

    assign pins_raw = '{mode:   ctrl_mode_e'(serial_mode_i),
                        par:    par_word_i,
                        preset: preset_sel_i,
                        sdata:  ser_data_i,
                        sclk:   ser_clk_i,
                        le:     latch_en_i};

    atten_pin_sync #(.WIDTH(PIN_W), .STAGES(SYNC_N)) u_sync (
        .clk (clk),
        .d   (pins_raw),
        .q   (pins_s)
    );

    assign serial_s  = (pins_s.mode == CTRL_SERIAL);
    assign init_word = serial_s ? pins_s.par : preset_word(pins_s.preset);

    atten_shift_reg u_shift (
        .clk        (clk),
        .rst        (rst),
        .enable     (serial_s),
        .sclk_s     (pins_s.sclk),
        .sdata_s    (pins_s.sdata),
        .init_word  (init_word),
        .shift_word (shift_word)
    );

    assign load_word = serial_s ? shift_word : pins_s.par;

    atten_word_reg u_word (
        .clk       (clk),
        .rst       (rst),
        .load      (pins_s.le),
        .init_word (init_word),
        .load_word (load_word),
        .word_o    (word_q)
    );

    assign atten_word_o = word_q;

    // R4 / R9: a closed latch freezes the output whatever the other pins do
    assert_latch_closed_R4: assert property (@(posedge clk) disable iff (rst)
        !pins_s.le |=> $stable(atten_word_o));

    // R3: open latch in parallel mode passes the synchronised pins
    assert_par_pass_R3: assert property (@(posedge clk) disable iff (rst)
        (pins_s.le && !serial_s) |=> (atten_word_o == $past(pins_s.par)));

    // R6: open latch in serial mode transfers the staged shift word
    assert_ser_xfer_R6: assert property (@(posedge clk) disable iff (rst)
        (pins_s.le && serial_s) |=> (atten_word_o == $past(shift_word)));

    // R1: first word after a parallel-mode reset is one of the four presets
    assert_preset_legal_R1: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && !$past(serial_s)) |->
        (atten_word_o inside {6'b000000, 6'b010000, 6'b100000, 6'b111110}));
endmodule

// File: tb/step_atten_ctrl_bench.sv
module step_atten_ctrl_bench;
    timeunit 1ns;
    timeprecision 1ps;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       serial_mode_i = 1'b0;
    logic [5:0] par_word_i = '0;
    logic [1:0] preset_sel_i = '0;
    logic       ser_data_i = 1'b0;
    logic       ser_clk_i = 1'b0;
    logic       latch_en_i = 1'b0;
    logic [5:0] atten_word_o;

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    done     = 1'b0;
    bit    model_ok = 1'b0;
    string cur_req  = "R1";

    always #4 clk = ~clk;

    step_atten_ctrl u_step_atten_ctrl (
        .clk           (clk),
        .rst           (rst),
        .serial_mode_i (serial_mode_i),
        .par_word_i    (par_word_i),
        .preset_sel_i  (preset_sel_i),
        .ser_data_i    (ser_data_i),
        .ser_clk_i     (ser_clk_i),
        .latch_en_i    (latch_en_i),
        .atten_word_o  (atten_word_o)
    );

    // ---------------- reference model ----------------
    typedef struct packed {
        logic       rst;
        logic       mode;
        logic [5:0] par;
        logic [1:0] pre;
        logic       d;
        logic       c;
        logic       le;
    } snap_t;

    snap_t      hist[$];
    snap_t      s2, s3;
    logic [5:0] exp_word = '0;
    logic [5:0] exp_sreg = '0;
    logic [5:0] nxt_sreg;

    function automatic logic [5:0] ref_preset(input logic [1:0] sel);
        if (sel == 2'd0) return 6'd0;     // 0 dB
        if (sel == 2'd1) return 6'd16;    // 8 dB
        if (sel == 2'd2) return 6'd32;    // 16 dB
        return 6'd62;                     // 31 dB
    endfunction

    always @(posedge clk) begin
        hist.push_front('{rst, serial_mode_i, par_word_i, preset_sel_i,
                          ser_data_i, ser_clk_i, latch_en_i});
        if (hist.size() > 6) void'(hist.pop_back());
        if (hist.size() >= 4) begin
            s2 = hist[2];   // pins as seen two edges back (after synchroniser)
            s3 = hist[3];
            if (hist[0].rst) begin
                exp_word = s2.mode ? s2.par : ref_preset(s2.pre);
                exp_sreg = exp_word;
                model_ok = 1'b1;
            end else if (model_ok) begin
                nxt_sreg = exp_sreg;
                if (s2.mode && s2.c && !s3.c) nxt_sreg = {exp_sreg[4:0], s2.d};
                if (s2.le) exp_word = s2.mode ? exp_sreg : s2.par;
                exp_sreg = nxt_sreg;
            end
        end
    end

    always @(negedge clk) begin
        if (model_ok && !rst && !done) begin
            n_checks++;
            if (atten_word_o !== exp_word) begin
                n_fail++;
                $display("FAIL %s per-cycle model: actual %b expected %b at %0t",
                         cur_req, atten_word_o, exp_word, $time);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [5:0] exp);
        n_checks++;
        if (atten_word_o !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, atten_word_o, exp);
        end
    endtask

    task automatic do_reset(input logic mode, input logic [5:0] par, input logic [1:0] pre);
        cyc(1);
        serial_mode_i = mode; par_word_i = par; preset_sel_i = pre;
        latch_en_i = 1'b0; ser_clk_i = 1'b0;
        rst = 1'b1;
        cyc(5);
        rst = 1'b0;
        cyc(4);
    endtask

    task automatic send_bit(input logic b);
        ser_data_i = b;
        cyc(2);
        ser_clk_i = 1'b1;
        cyc(3);
        ser_clk_i = 1'b0;
        cyc(3);
    endtask

    task automatic send_bits(input logic [8:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic le_pulse();
        latch_en_i = 1'b1;
        cyc(3);
        latch_en_i = 1'b0;
        cyc(4);
    endtask

    // ---------------- scenarios ----------------
    initial begin
        logic [5:0] w_old;
        logic [5:0] w_new;

        // R1 / R10: every preset code in parallel mode
        cur_req = "R1";
        for (int p = 0; p < 4; p++) begin
            do_reset(1'b0, 6'b101101, p[1:0]);
            chk("R1 preset", ref_preset(p[1:0]));
        end
        cur_req = "R10";
        do_reset(1'b0, 6'b000000, 2'b11);
        chk("R10 31 dB weight", 6'b111110);

        // R2: serial-mode power-up copies parallel pins, shift reg too
        cur_req = "R2";
        do_reset(1'b1, 6'h2B, 2'b11);
        chk("R2 serial power-up", 6'h2B);
        le_pulse();
        chk("R2 shift reg init", 6'h2B);

        // R3: direct parallel
        cur_req = "R3";
        do_reset(1'b0, 6'h00, 2'b00);
        latch_en_i = 1'b1;
        foreach (w_new[i]) begin
            par_word_i = 6'(1 << i);
            cyc(4);
            chk("R3 direct", 6'(1 << i));
        end
        par_word_i = 6'h3F;
        cyc(4);
        chk("R3 direct 31.5 dB", 6'h3F);

        // R4: latch closed, pins wander
        cur_req = "R4";
        latch_en_i = 1'b0;
        cyc(4);
        par_word_i = 6'h15;
        cyc(3);
        par_word_i = 6'h2A;
        cyc(4);
        chk("R4 hold", 6'h3F);

        // R5: strobed parallel load
        cur_req = "R5";
        par_word_i = 6'h0C;
        cyc(2);
        le_pulse();
        par_word_i = 6'h33;
        cyc(5);
        chk("R5 latched", 6'h0C);

        // R6 / R7: serial loads of random words
        cur_req = "R6";
        do_reset(1'b1, 6'h00, 2'b00);
        w_old = 6'h00;
        for (int k = 0; k < 4; k++) begin
            w_new = 6'($urandom);
            cur_req = "R7";
            send_bits({3'b000, w_new}, 6);
            chk("R7 stable while shifting", w_old);
            cur_req = "R6";
            le_pulse();
            chk("R6 serial load", w_new);
            w_old = w_new;
        end
        send_bits({3'b000, 6'b100000}, 6);
        le_pulse();
        chk("R6 MSB first", 6'b100000);

        // R8: nine bits, last six kept
        cur_req = "R8";
        send_bits(9'b101_101001, 9);
        le_pulse();
        chk("R8 last six", 6'b101001);

        // R9: mode change with latch closed
        cur_req = "R9";
        par_word_i = 6'h17;
        serial_mode_i = 1'b0;
        cyc(6);
        chk("R9 mode to parallel", 6'b101001);
        serial_mode_i = 1'b1;
        cyc(6);
        chk("R9 mode to serial", 6'b101001);
        serial_mode_i = 1'b0;
        cyc(3);
        cur_req = "R5";
        le_pulse();
        chk("R5 load after mode change", 6'h17);

        cyc(3);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule